// File: doc/BRIEF.md
# Programmable FIFO Word Unpacker

This block sits between a transmit FIFO and a serial protocol sequencer. It accepts one 32-bit FIFO entry at a time over a valid/ready handshake. It then emits the bits of that entry one per handshake on a serial valid/ready output. Which bits are sent, and in what order, is set at run time by up to four 10-bit packing vectors. Each vector gives a start bit index, a walking direction, a run length of one to eight bits, and a stop flag. The stop flag closes the current entry. A 2-bit granularity code tells the block how many protocol words share an entry. From this code it marks the last bit of each protocol word, so that a downstream sequencer can insert framing.

Software writes two packing registers and the granularity code through a small write-only register port. A snapshot of the vectors and of the granularity is taken each time a FIFO entry is accepted. This means a write never disturbs the entry that is being unpacked.

The controller is a three-state machine. ST_IDLE waits for a FIFO entry. ST_EMIT walks the vectors and sends bits. ST_BADCFG holds the block quiet while the granularity code is the undefined value 3. The transitions are:
- ST_IDLE to ST_EMIT on an accepted entry.
- ST_IDLE to ST_BADCFG when the live code is 3 and no entry is accepted.
- ST_BADCFG to ST_IDLE once the code is legal again.
- ST_EMIT to ST_IDLE on the handshake of the last bit of the entry.

Top module: `fifo_word_unpacker`

## Requirements
- R1: A packing vector is 10 bits: [9:5] start index, [4] direction, [3:1] run length minus one, [0] stop. A write with `cfg_addr`=0 loads vector 0 from `cfg_wdata[9:0]` and vector 1 from `cfg_wdata[19:10]`. `cfg_addr`=1 loads vectors 2 and 3 in the same positions. `cfg_addr`=2 loads the granularity code from `cfg_wdata[1:0]`.
- R2: Within a vector, the first bit sent is at the start index. Each later bit index is one lower when direction is 1 and one higher when direction is 0, wrapping modulo 32. A vector sends length-code + 1 bits.
- R3: Vectors run in order from vector 0. The entry ends after the run of the first vector whose stop flag is set. `bit_last` is 1 exactly on that final bit. After its handshake, `bit_valid` is 0 until a new entry is accepted, and that entry starts again at vector 0.
- R4: If vectors 0 to 3 all have stop clear, the entry ends after vector 3.
- R5: `word_end` is 1 on the last bit of a vector's run when any of these holds: the entry ends there; the captured granularity code is 0 (four 8-bit words); or the code is 1 (two 16-bit words) and the vector number is odd. With code 2 (one 32-bit word), it marks only the entry's final bit.
- R6: While the live granularity code is 3 and the block is idle, `fifo_ready` and `bit_valid` are 0. From the following cycle `gran_err` is 1, until the code becomes legal.
- R7: A register write made while an entry is being unpacked does not change that entry's bits. It applies from the next accepted entry.
- R8: While `bit_valid` is 1 and `bit_ready` is 0, `bit_data`, `bit_last` and `word_end` hold. `fifo_ready` is never 1 while `bit_valid` is 1.
- R9: After reset: `bit_valid`=0, `gran_err`=0, `fifo_ready`=1, the granularity code is 0, and all vectors are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 vectors 0/1, 1 vectors 2/3, 2 granularity |
| cfg_wdata | input | 20 | Register write data |
| fifo_valid | input | 1 | FIFO entry available |
| fifo_data | input | 32 | FIFO entry |
| fifo_ready | output | 1 | Entry accepted when high with fifo_valid |
| bit_valid | output | 1 | Serial bit available |
| bit_data | output | 1 | Serial bit |
| bit_ready | input | 1 | Downstream takes the bit |
| bit_last | output | 1 | Final bit of the FIFO entry |
| word_end | output | 1 | Final bit of a protocol word |
| gran_err | output | 1 | Undefined granularity code present |

## Verification
The assertions check every cycle that held output bits stay stable, and that the FIFO and bit handshakes never overlap. They also check that each run walks the index by one in the chosen direction, and that a new entry restarts at vector 0. In addition, every entry-final bit must also mark a word end, and the fault state must stay quiet. The actual bit order for a given vector set is shown only by the bench, which compares against a bench-side model. This includes stop placement, the rule for a missing stop, word-end placement under each granularity, and isolation from mid-entry register writes.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
    localparam int WORD_W      = 32;
    localparam int IDX_W       = $clog2(WORD_W);
    localparam int NUM_VEC     = 4;
    localparam int VEC_W       = 10;
    localparam int VEC_PER_REG = 2;
    localparam int NUM_REGS    = NUM_VEC / VEC_PER_REG;
    localparam int REG_W       = VEC_PER_REG * VEC_W;

    // Packed field order is the bit layout: start[9:5] dir[4] run[3:1] stop[0]
    typedef struct packed {
        logic [IDX_W-1:0] start;
        logic             msb_first;
        logic [2:0]       run_code;
        logic             stop;
    } pack_vec_t;

    localparam logic [1:0] GRAN_4X8  = 2'd0;
    localparam logic [1:0] GRAN_2X16 = 2'd1;
    localparam logic [1:0] GRAN_1X32 = 2'd2;
    localparam logic [1:0] GRAN_BAD  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_BADCFG = 2'd2
    } unpk_state_t;
endpackage

// File: rtl/unpk_cfg_regs.sv
module unpk_cfg_regs
    import unpk_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [1:0]                 addr,
    input  logic [REG_W-1:0]           wdata,
    output pack_vec_t [NUM_VEC-1:0]    vecs,
    output logic [1:0]                 gran
);
    logic [REG_W-1:0] pack_q [NUM_REGS];
    logic [1:0]       gran_q;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pack_q[r] <= '0;
            end else if (we && (addr == 2'(r))) begin
                pack_q[r] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gran_q <= GRAN_4X8;
        end else if (we && (addr == 2'(NUM_REGS))) begin
            gran_q <= wdata[1:0];
        end
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        assign vecs[v] = pack_pkg_slice(pack_q[v / VEC_PER_REG], v % VEC_PER_REG);
    end

    assign gran = gran_q;

    function automatic pack_vec_t pack_pkg_slice(input logic [REG_W-1:0] r, input int slot);
        return pack_vec_t'(r[slot*VEC_W +: VEC_W]);
    endfunction

    // R1: a granularity write lands in the code the next cycle
    p_gran_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'(NUM_REGS)) |=> (gran == $past(wdata[1:0])));
endmodule

// File: rtl/unpk_capture.sv
module unpk_capture
    import unpk_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [WORD_W-1:0]          word_in,
    input  pack_vec_t [NUM_VEC-1:0]    vecs_in,
    input  logic [1:0]                 gran_in,
    input  logic [IDX_W-1:0]           sel_idx,
    output pack_vec_t [NUM_VEC-1:0]    vecs_held,
    output logic [1:0]                 gran_held,
    output logic                       sel_bit
);
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            vecs_held <= '0;
            gran_held <= GRAN_4X8;
        end else if (load) begin
            word_q    <= word_in;
            vecs_held <= vecs_in;
            gran_held <= gran_in;
        end
    end

    assign sel_bit = word_q[sel_idx];

    // R7: the snapshot only moves on a load
    p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(vecs_held) && $stable(gran_held)));
endmodule

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
    import unpk_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 gran_live,
    input  logic [1:0]                 gran_held,
    input  pack_vec_t [NUM_VEC-1:0]    vecs,
    input  logic                       in_valid,
    output logic                       in_ready,
    output logic                       load,
    input  logic                       bit_ready,
    output logic                       bit_valid,
    output logic [IDX_W-1:0]           bit_idx,
    output logic                       bit_last,
    output logic                       word_end,
    output logic                       gran_err
);
    localparam int SEL_W = $clog2(NUM_VEC);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_VEC - 1);

    unpk_state_t      state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic [2:0]       cnt_q;
    pack_vec_t        cur;
    logic             run_end, entry_end, fire, bad_code;

    assign cur       = vecs[sel_q];
    assign bad_code  = (gran_live == GRAN_BAD);
    assign run_end   = (cnt_q == cur.run_code);
    assign entry_end = run_end && (cur.stop || sel_q == LAST_SEL);
    assign fire      = bit_valid && bit_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && !bad_code) state_d = ST_EMIT;
                else if (bad_code)         state_d = ST_BADCFG;
            end
            ST_EMIT: begin
                if (fire && entry_end) state_d = ST_IDLE;
            end
            ST_BADCFG: begin
                if (!bad_code) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        bit_valid = 1'b0;
        gran_err  = 1'b0;
        unique case (state_q)
            ST_IDLE:   in_ready  = !bad_code;
            ST_EMIT:   bit_valid = 1'b1;
            ST_BADCFG: gran_err  = 1'b1;
            default:   in_ready  = 1'b0;
        endcase
        load     = in_ready && in_valid;
        bit_last = bit_valid && entry_end;
        word_end = bit_valid && run_end &&
                   (entry_end || gran_held == GRAN_4X8 ||
                    (gran_held == GRAN_2X16 && sel_q[0]));
        bit_idx  = cur.msb_first ? (cur.start - IDX_W'(cnt_q))
                                 : (cur.start + IDX_W'(cnt_q));
    end

    // Vector walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else if (fire) begin
            if (run_end) begin
                sel_q <= sel_q + 1'b1;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8: a held bit keeps its value and markers
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_idx) &&
                                       $stable(bit_last) && $stable(word_end)));
    // R8: the two handshakes never overlap
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && bit_valid));
    // R3: nothing follows the entry's final bit until a new entry
    p_last_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && bit_last) |=> !bit_valid);
    // R3: a new entry restarts at vector 0, first bit of its run
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_valid) |-> (sel_q == '0 && cnt_q == '0));
    // R2: inside a run the index steps by one in the chosen direction
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !run_end) |=> (bit_idx == ($past(cur.msb_first) ?
                                 $past(bit_idx) - 1'b1 : $past(bit_idx) + 1'b1)));
    // R5: the entry's final bit always closes a protocol word
    p_wend_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_last |-> word_end);
    // R6: the fault state is quiet
    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gran_err |-> (!bit_valid && !in_ready));
endmodule

// File: rtl/fifo_word_unpacker.sv
module fifo_word_unpacker
    import unpk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic                 fifo_valid,
    input  logic [WORD_W-1:0]    fifo_data,
    output logic                 fifo_ready,
    output logic                 bit_valid,
    output logic                 bit_data,
    input  logic                 bit_ready,
    output logic                 bit_last,
    output logic                 word_end,
    output logic                 gran_err
);
    pack_vec_t [NUM_VEC-1:0] vecs_live, vecs_held;
    logic [1:0]              gran_live, gran_held;
    logic                    load;
    logic [IDX_W-1:0]        bit_idx;

    unpk_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .vecs  (vecs_live),
        .gran  (gran_live)
    );

    unpk_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .word_in   (fifo_data),
        .vecs_in   (vecs_live),
        .gran_in   (gran_live),
        .sel_idx   (bit_idx),
        .vecs_held (vecs_held),
        .gran_held (gran_held),
        .sel_bit   (bit_data)
    );

    unpk_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .gran_live (gran_live),
        .gran_held (gran_held),
        .vecs      (vecs_held),
        .in_valid  (fifo_valid),
        .in_ready  (fifo_ready),
        .load      (load),
        .bit_ready (bit_ready),
        .bit_valid (bit_valid),
        .bit_idx   (bit_idx),
        .bit_last  (bit_last),
        .word_end  (word_end),
        .gran_err  (gran_err)
    );
endmodule

// File: tb/fifo_word_unpacker_tb.sv
module fifo_word_unpacker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [19:0] cfg_wdata = '0;
    logic        fifo_valid = 1'b0;
    logic [31:0] fifo_data = '0;
    logic        fifo_ready, bit_valid, bit_data, bit_last, word_end, gran_err;
    logic        bit_ready = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic       exp_bit  [32];
    logic       exp_last [32];
    logic       exp_wend [32];
    int         exp_n;

    always #2 clk = ~clk;

    fifo_word_unpacker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_ready(fifo_ready), .bit_valid(bit_valid), .bit_data(bit_data),
        .bit_ready(bit_ready), .bit_last(bit_last), .word_end(word_end),
        .gran_err(gran_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [9:0] mkvec(input int st, input int dir, input int len, input int stp);
        return {5'(st), 1'(dir), 3'(len), 1'(stp)};
    endfunction

    // Bench model of the requirements R1..R5
    task automatic model(input logic [19:0] c0, input logic [19:0] c1,
                         input logic [1:0] g, input logic [31:0] w);
        exp_n = 0;
        for (int v = 0; v < 4; v++) begin
            logic [9:0] vec;
            logic       endw;
            vec  = (v < 2) ? c0[v*10 +: 10] : c1[(v-2)*10 +: 10];
            endw = vec[0] || (v == 3);
            for (int k = 0; k <= int'(vec[3:1]); k++) begin
                logic [4:0] idx;
                idx = vec[4] ? (vec[9:5] - 5'(k)) : (vec[9:5] + 5'(k));
                exp_bit[exp_n]  = w[idx];
                exp_last[exp_n] = endw && (k == int'(vec[3:1]));
                exp_wend[exp_n] = (k == int'(vec[3:1])) &&
                                  (endw || g == 2'd0 || (g == 2'd1 && v[0]));
                exp_n++;
            end
            if (endw) break;
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [19:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Sends one entry and checks every emitted bit; optional mid-entry write of vectors 0/1
    task automatic run_word(input logic [19:0] c0, input logic [19:0] c1, input logic [1:0] g,
                            input logic [31:0] w, input bit prog, input bit rnd_ready,
                            input bit mid, input logic [19:0] mid_c0, input string tag);
        int  got, cyc;
        bit  accepted, acc_now, mid_done, prev_stall;
        logic prev_bit;
        if (prog) begin
            cfg_write(2'd0, c0);
            cfg_write(2'd1, c1);
            cfg_write(2'd2, {18'd0, g});
        end
        model(c0, c1, g, w);
        got = 0; cyc = 0; accepted = 0; mid_done = 0; prev_stall = 0; prev_bit = 0;
        @(negedge clk);
        fifo_valid = 1'b1; fifo_data = w;
        while (got < exp_n && cyc < 600) begin
            cyc++;
            acc_now = 0;
            bit_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
            if (mid && accepted && !mid_done) begin
                cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = mid_c0; mid_done = 1;
            end else begin
                cfg_we = 1'b0;
            end
            #1;
            if (!accepted && fifo_valid && fifo_ready) acc_now = 1;
            if (prev_stall && bit_valid)
                check(bit_data == prev_bit, {tag, " R8 held bit"}, bit_data, prev_bit);
            if (bit_valid && bit_ready) begin
                check(bit_data == exp_bit[got], {tag, " R2 bit value"}, bit_data, exp_bit[got]);
                check(bit_last == exp_last[got], {tag, " R3 R4 last marker"}, bit_last, exp_last[got]);
                check(word_end == exp_wend[got], {tag, " R5 word end"}, word_end, exp_wend[got]);
                got++;
                prev_stall = 0;
            end else begin
                prev_stall = bit_valid;
                prev_bit   = bit_data;
            end
            @(negedge clk);
            if (acc_now) begin
                fifo_valid = 1'b0;
                accepted = 1;
            end
        end
        cfg_we = 1'b0;
        bit_ready = 1'b0;
        check(got == exp_n, {tag, " R3 bit count"}, got, exp_n);
        #1;
        check(bit_valid == 1'b0, {tag, " R3 quiet after last"}, bit_valid, 0);
    endtask

    initial begin
        logic [19:0] c0, c1, nc0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        check(bit_valid == 1'b0, "R9 bit_valid", bit_valid, 0);
        check(fifo_ready == 1'b1, "R9 fifo_ready", fifo_ready, 1);
        check(gran_err == 1'b0, "R9 gran_err", gran_err, 0);
        // R9 zero vectors, code 0: four single bits at index 0
        run_word(20'd0, 20'd0, 2'd0, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 20'd0, "R9 default");

        // R1 R2 seven-bit words, four per entry, MSB first
        c0 = {mkvec(14,1,6,0), mkvec(6,1,6,0)};
        c1 = {mkvec(30,1,6,1), mkvec(22,1,6,0)};
        run_word(c0, c1, 2'd0, 32'h5A3C_96E1, 1'b1, 1'b0, 1'b0, 20'd0, "ex7x4");
        // R2 fifteen-bit words, two per entry, LSB first
        c0 = {mkvec(8,0,6,0), mkvec(0,0,7,0)};
        c1 = {mkvec(24,0,6,1), mkvec(16,0,7,0)};
        run_word(c0, c1, 2'd1, 32'hC0FF_EE42, 1'b1, 1'b1, 1'b0, 20'd0, "ex15x2");
        // R3 one 23-bit word, stop on vector 2, vector 3 ignored
        c0 = {mkvec(14,1,7,0), mkvec(22,1,7,0)};
        c1 = {mkvec(31,0,7,1), mkvec(6,1,6,1)};
        run_word(c0, c1, 2'd2, 32'h0071_B3D5, 1'b1, 1'b1, 1'b0, 20'd0, "ex23x1");
        // R4 no stop anywhere, with index wrap past 0 and past 31
        c0 = {mkvec(29,0,7,0), mkvec(2,1,7,0)};
        c1 = {mkvec(5,0,3,0), mkvec(17,1,1,0)};
        run_word(c0, c1, 2'd1, 32'hA5A5_0F0F, 1'b1, 1'b1, 1'b0, 20'd0, "R4 nostop");

        // R7 mid-entry rewrite of vectors 0/1 applies only to the next entry
        c0 = {mkvec(8,0,7,0), mkvec(0,0,7,0)};
        c1 = {mkvec(24,0,7,1), mkvec(16,0,7,0)};
        nc0 = {mkvec(31,1,7,0), mkvec(3,1,3,1)};
        run_word(c0, c1, 2'd2, 32'h1357_9BDF, 1'b1, 1'b0, 1'b1, nc0, "R7 old");
        run_word(nc0, c1, 2'd2, 32'h2468_ACE0, 1'b0, 1'b1, 1'b0, 20'd0, "R7 new");

        // R6 undefined granularity code
        cfg_write(2'd2, 20'd3);
        @(negedge clk);
        fifo_valid = 1'b1; fifo_data = 32'hFFFF_FFFF;
        for (int i = 0; i < 4; i++) begin
            #1;
            check(fifo_ready == 1'b0, "R6 fifo_ready low", fifo_ready, 0);
            check(bit_valid == 1'b0, "R6 no bits", bit_valid, 0);
            check(gran_err == 1'b1, "R6 gran_err", gran_err, 1);
            @(negedge clk);
        end
        fifo_valid = 1'b0;
        cfg_write(2'd2, 20'd0);
        @(negedge clk); #1;
        check(gran_err == 1'b0, "R6 gran_err clears", gran_err, 0);
        run_word(20'd0, 20'd0, 2'd0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 20'd0, "R6 recover");

        // Random vectors, codes 0..2, random backpressure (R1 R2 R3 R4 R5 R8)
        for (int n = 0; n < 150; n++) begin
            c0 = 20'($urandom);
            c1 = 20'($urandom);
            run_word(c0, c1, 2'($urandom % 3), $urandom, 1'b1, 1'b1, 1'b0, 20'd0, "rand");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule